// File: doc/BRIEF.md
# I2C Register-Access Target

This block is an I2C target (slave) that lets a host on a two-wire bus read and write an internal register file. It oversamples SCL and SDA with the system clock, detects start, repeated-start and stop conditions, and answers one 7-bit address. The top six address bits are fixed at `100111`. The lowest address bit follows a strap input, so two such targets can share one bus.

In a write transfer, the first byte after the address byte is a pointer byte. Bit 7 of this byte is an auto-increment flag and bits 6..0 select a register. Each later byte is stored into the selected register. In a read transfer, the block sends out the selected register, most significant bit first. When the flag is set, the pointer steps to the next register after every data byte, in both directions. The pointer keeps its value across stop and repeated-start conditions. A host can therefore set the pointer in a short write and then read from that register.

The register file stays outside the block. The block presents a register index and a one-cycle write strobe with write data, and it expects read data to follow the index in the same cycle. SDA is open-drain: the block only asserts an output enable that pulls the line low.

Top module: `i2c_regfile_target`

## Requirements
- R1: An address byte `{1,0,0,1,1,1,addr_strap,rw}` received after a start or repeated start is acknowledged: `sda_oe` pulls SDA low during the ninth SCL pulse. `rw`=1 selects a read and `rw`=0 selects a write.
- R2: An address byte that does not match gets no acknowledge. The block then keeps SDA released and writes no register until the next start condition, even when more bytes follow.
- R3: In a write, the byte after the address loads the pointer. Its bits 6..0 give the register index. Each further byte produces exactly one single-cycle `reg_wr_en` pulse, with `reg_addr` set to the pointer and `reg_wr_data` set to the byte.
- R4: When bit 7 of the pointer byte is 1, the pointer increments by one after each data byte and wraps from 127 to 0. When bit 7 is 0, the pointer stays fixed. The pointer never changes in any other way.
- R5: In a read, the block drives the selected register onto SDA, MSB first, while SCL is low. Each host acknowledge makes it send the next byte, which follows the R4 pointer rule.
- R6: A not-acknowledge from the host after a transmitted byte ends the read, and SDA is released.
- R7: The pointer keeps its value across repeated-start and stop conditions. A pointer write followed by a read, joined by either condition, returns the selected register.
- R8: A stop condition (SDA rising while SCL is high) returns the block to idle with SDA released, even in the middle of a byte.
- R9: While reset is asserted, and in the cycle after it, `sda_oe` and `reg_wr_en` are low.
- R10: Every byte the block receives after a matching address, whether pointer or data, is acknowledged. The block changes `sda_oe` only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| addr_strap | input | 1 | Level of the least significant address bit |
| reg_addr | output | IDX_W | Register index (current pointer) |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_data | output | 8 | Data for the register write |
| reg_rd_data | input | 8 | Contents of the register at `reg_addr` |

## Verification
The bench builds the block with its default parameters: a 7-bit register index, two synchroniser stages and the fixed upper address `100111`. With the full 7-bit index, the testbench can reach every register and can exercise the pointer wrap from 127 to 0. Both strap levels, strap-mismatched addresses and randomly mixed incrementing and fixed transfers are checked against a register model in the bench. Reads are joined to pointer writes by repeated starts and also by stops.

// File: rtl/i2c_tgt_pkg.sv
// Package: shared types for the I2C register-access target.
// Assumes a byte-oriented bus; BYTE_W is fixed by the protocol.
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;

    // Protocol phase of the controller
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } ctl_state_t;

    // Meaning of the byte currently being received
    typedef enum logic [1:0] {
        RX_ADDR,
        RX_PTR,
        RX_DATA
    } rx_kind_t;

endpackage

// File: rtl/i2c_tgt_line_mon.sv
// Line monitor: synchronises SCL and SDA into clk, then reports SCL edges
// and start/stop conditions as one-cycle events.
// Assumes clk is at least several times faster than SCL; idle bus is high.
module i2c_tgt_line_mon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] scl_chain;
    logic [SYNC_STAGES-1:0] sda_chain;
    logic                   scl_q;
    logic                   sda_q;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First synchroniser flop, reset to the idle-high level
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_chain[0] <= 1'b1;
                    sda_chain[0] <= 1'b1;
                end else begin
                    scl_chain[0] <= scl_i;
                    sda_chain[0] <= sda_i;
                end
            end
        end else begin : g_next
            // Further synchroniser flops
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_chain[g] <= 1'b1;
                    sda_chain[g] <= 1'b1;
                end else begin
                    scl_chain[g] <= scl_chain[g-1];
                    sda_chain[g] <= sda_chain[g-1];
                end
            end
        end
    end

    assign scl_lvl = scl_chain[LAST];
    assign sda_lvl = sda_chain[LAST];

    // Previous synchronised levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_lvl;
            sda_q <= sda_lvl;
        end
    end

    // Edge and condition decode; conditions need SCL high on both samples
    always_comb begin
        scl_rise  = scl_lvl & ~scl_q;
        scl_fall  = ~scl_lvl & scl_q;
        start_evt = scl_lvl & scl_q & sda_q & ~sda_lvl;
        stop_evt  = scl_lvl & scl_q & ~sda_q & sda_lvl;
    end

endmodule

// File: rtl/i2c_tgt_ptr.sv
// Register pointer: holds the register index and the auto-increment flag
// taken from the pointer byte (bit 7 = flag, low bits = index).
// Assumes load and step never coincide; IDX_W is at most 7.
module i2c_tgt_ptr #(
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [7:0]       load_byte,
    input  logic             step,
    output logic [IDX_W-1:0] idx,
    output logic             auto_inc
);

    localparam int INC_BIT = 7;

    // Pointer update: load from a pointer byte, or step when enabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx      <= '0;
            auto_inc <= 1'b0;
        end else if (load) begin
            idx      <= load_byte[IDX_W-1:0];
            auto_inc <= load_byte[INC_BIT];
        end else if (step && auto_inc) begin
            idx      <= idx + 1'b1;
        end
    end

endmodule

// File: rtl/i2c_tgt_ctrl.sv
// Protocol controller: byte framing, address match, acknowledge generation,
// pointer/data handling for writes and bit-serial transmit for reads.
// Assumes events come from i2c_tgt_line_mon; read data follows the pointer
// combinationally through the register file.
module i2c_tgt_ctrl
    import i2c_tgt_pkg::*;
#(
    parameter logic [5:0] ADDR_HI = 6'b100111
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              addr_strap,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic              ptr_load,
    output logic [BYTE_W-1:0] ptr_byte,
    output logic              ptr_step,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_byte,
    output logic              sda_oe
);

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    ctl_state_t        st;
    rx_kind_t          kind;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_sr;
    logic [BYTE_W-1:0] tx_sr;
    logic              is_read;
    logic              host_ack;
    logic              rx_done;
    logic              tx_done;
    logic              addr_hit;

    // Byte completion and address compare
    always_comb begin
        rx_done  = (st == ST_RX) && scl_fall && (bit_cnt == FULL);
        tx_done  = (st == ST_TX) && scl_fall && (bit_cnt == FULL);
        addr_hit = (rx_sr[7:1] == {ADDR_HI, addr_strap});
    end

    // Strobes towards pointer and register file
    always_comb begin
        ptr_load = rx_done && (kind == RX_PTR);
        ptr_byte = rx_sr;
        wr_en    = rx_done && (kind == RX_DATA);
        wr_byte  = rx_sr;
        ptr_step = wr_en || tx_done;
    end

    // Protocol sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            kind     <= RX_ADDR;
            bit_cnt  <= '0;
            rx_sr    <= '0;
            tx_sr    <= '0;
            is_read  <= 1'b0;
            host_ack <= 1'b0;
            sda_oe   <= 1'b0;
        end else if (start_evt) begin
            st      <= ST_RX;
            kind    <= RX_ADDR;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
        end else if (stop_evt) begin
            st      <= ST_IDLE;
            sda_oe  <= 1'b0;
        end else begin
            case (st)
                ST_RX: begin
                    if (scl_rise && bit_cnt != FULL) begin
                        rx_sr   <= {rx_sr[BYTE_W-2:0], sda_lvl};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                    if (rx_done) begin
                        if (kind == RX_ADDR && !addr_hit) begin
                            st <= ST_IDLE;
                        end else begin
                            sda_oe <= 1'b1;
                            st     <= ST_RX_ACK;
                            if (kind == RX_ADDR) begin
                                is_read <= rx_sr[0];
                            end
                        end
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (kind == RX_ADDR && is_read) begin
                            tx_sr  <= rd_byte;
                            sda_oe <= ~rd_byte[BYTE_W-1];
                            st     <= ST_TX;
                        end else begin
                            sda_oe <= 1'b0;
                            st     <= ST_RX;
                            kind   <= (kind == RX_ADDR) ? RX_PTR : RX_DATA;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise && bit_cnt != FULL) begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                    if (tx_done) begin
                        sda_oe <= 1'b0;
                        st     <= ST_TX_ACK;
                    end else if (scl_fall) begin
                        tx_sr  <= {tx_sr[BYTE_W-2:0], 1'b0};
                        sda_oe <= ~tx_sr[BYTE_W-2];
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        host_ack <= ~sda_lvl;
                    end
                    if (scl_fall) begin
                        if (host_ack) begin
                            tx_sr   <= rd_byte;
                            sda_oe  <= ~rd_byte[BYTE_W-1];
                            bit_cnt <= '0;
                            st      <= ST_TX;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                default: begin
                    st <= ST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/i2c_regfile_target.sv
// Top: I2C target giving a bus host pointer-based read/write access to an
// external register file. Assumes clk oversamples SCL by a wide margin and
// that reg_rd_data reflects reg_addr in the same cycle.
module i2c_regfile_target #(
    parameter int         IDX_W       = 7,
    parameter int         SYNC_STAGES = 2,
    parameter logic [5:0] ADDR_HI     = 6'b100111
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    input  logic             addr_strap,
    output logic [IDX_W-1:0] reg_addr,
    output logic             reg_wr_en,
    output logic [7:0]       reg_wr_data,
    input  logic [7:0]       reg_rd_data
);

    logic       scl_lvl;
    logic       sda_lvl;
    logic       scl_rise;
    logic       scl_fall;
    logic       start_evt;
    logic       stop_evt;
    logic       ptr_load;
    logic [7:0] ptr_byte;
    logic       ptr_step;
    logic       auto_inc;

    i2c_tgt_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    i2c_tgt_ptr #(.IDX_W(IDX_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ptr_load),
        .load_byte (ptr_byte),
        .step      (ptr_step),
        .idx       (reg_addr),
        .auto_inc  (auto_inc)
    );

    i2c_tgt_ctrl #(.ADDR_HI(ADDR_HI)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_lvl    (sda_lvl),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_evt  (start_evt),
        .stop_evt   (stop_evt),
        .addr_strap (addr_strap),
        .rd_byte    (reg_rd_data),
        .ptr_load   (ptr_load),
        .ptr_byte   (ptr_byte),
        .ptr_step   (ptr_step),
        .wr_en      (reg_wr_en),
        .wr_byte    (reg_wr_data),
        .sda_oe     (sda_oe)
    );

endmodule

// File: rtl/i2c_regfile_target_chk.sv
// Checker: temporal properties of the I2C register-access target, bound
// to the top module. Observes ports and signals between sub-blocks.
module i2c_regfile_target_chk #(
    parameter int IDX_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sda_oe,
    input logic             reg_wr_en,
    input logic [IDX_W-1:0] reg_addr,
    input logic             scl_lvl,
    input logic             stop_evt,
    input logic             ptr_load
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!sda_oe && !reg_wr_en)); // R9

    AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en); // R3

    AST_PTR_ONLY_LOAD_OR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_addr != $past(reg_addr)) && !$past(ptr_load))
            |-> (reg_addr == $past(reg_addr) + {{(IDX_W-1){1'b0}}, 1'b1})); // R4

    AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !$past(scl_lvl)); // R10

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_oe); // R8

endmodule

bind i2c_regfile_target i2c_regfile_target_chk #(.IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_oe    (sda_oe),
    .reg_wr_en (reg_wr_en),
    .reg_addr  (reg_addr),
    .scl_lvl   (scl_lvl),
    .stop_evt  (stop_evt),
    .ptr_load  (ptr_load)
);

// File: tb/i2c_regfile_target_tb.sv
module i2c_regfile_target_tb;

    localparam int Q     = 8;
    localparam int IDX_W = 7;
    localparam int NREG  = 1 << IDX_W;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             rst_n;
    logic             scl_drv;
    logic             host_low;
    logic             strap;
    logic             sda_oe;
    logic             sda_bus;
    logic [IDX_W-1:0] reg_addr;
    logic             reg_wr_en;
    logic [7:0]       reg_wr_data;
    logic [7:0]       reg_rd_data;

    logic [7:0] rf    [NREG];
    logic [7:0] model [NREG];
    logic [7:0] wbuf  [8];

    int  checks = 0;
    int  errors = 0;
    bit  finished = 0;

    assign sda_bus     = !(host_low || sda_oe);
    assign reg_rd_data = rf[reg_addr];

    always @(posedge clk) begin
        if (reg_wr_en) rf[reg_addr] <= reg_wr_data;
    end

    i2c_regfile_target u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_drv),
        .sda_i       (sda_bus),
        .sda_oe      (sda_oe),
        .addr_strap  (strap),
        .reg_addr    (reg_addr),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_data (reg_wr_data),
        .reg_rd_data (reg_rd_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n = 1);
        repeat (n * Q) @(posedge clk);
        #1;
    endtask

    function automatic logic [7:0] addr_byte(input logic s, input logic rw);
        return {6'b100111, s, rw};
    endfunction

    function automatic int nxt(input int p, input bit inc);
        return inc ? (p + 1) % NREG : p;
    endfunction

    task automatic bus_start();
        host_low = 0; scl_drv = 1; wq();
        host_low = 1; wq();
        scl_drv = 0; wq();
    endtask

    task automatic bus_rstart();
        host_low = 0; wq();
        scl_drv = 1; wq();
        host_low = 1; wq();
        scl_drv = 0; wq();
    endtask

    task automatic bus_stop();
        host_low = 1; wq();
        scl_drv = 1; wq();
        host_low = 0; wq();
    endtask

    task automatic send_bits(input logic [7:0] b, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            host_low = !b[i]; wq();
            scl_drv = 1; wq(2);
            scl_drv = 0; wq();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        send_bits(b, 8);
        host_low = 0; wq();
        scl_drv = 1; wq();
        acked = !sda_bus; wq();
        scl_drv = 0; wq();
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit last);
        for (int i = 7; i >= 0; i--) begin
            wq();
            scl_drv = 1; wq();
            b[i] = sda_bus; wq();
            scl_drv = 0;
        end
        host_low = !last; wq();
        scl_drv = 1; wq(2);
        scl_drv = 0; wq();
        host_low = 0;
    endtask

    // Write n bytes from wbuf starting at idx; updates the bench model
    task automatic do_write(input int idx, input bit inc, input int n);
        bit a;
        int p = idx;
        bus_start();
        send_byte(addr_byte(strap, 1'b0), a);
        chk(a, "R1 addr ack (write)", a, 1);
        send_byte({inc, 7'(idx)}, a);
        chk(a, "R10 pointer ack", a, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], a);
            chk(a, "R10 data ack", a, 1);
            model[p] = wbuf[i];
            p = nxt(p, inc);
        end
        bus_stop();
        wq();
        chk(sda_oe == 0, "R8 released after stop", sda_oe, 0);
    endtask

    // Set pointer, join with repeated start or stop, then read n bytes
    task automatic do_read(input int idx, input bit inc, input int n, input bit rs);
        bit a;
        logic [7:0] b;
        int p = idx;
        bus_start();
        send_byte(addr_byte(strap, 1'b0), a);
        send_byte({inc, 7'(idx)}, a);
        if (rs) bus_rstart();
        else begin bus_stop(); bus_start(); end
        send_byte(addr_byte(strap, 1'b1), a);
        chk(a, "R1 addr ack (read)", a, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(b, i == n - 1);
            chk(b == model[p], rs ? "R5/R7 read data (rstart)" : "R5/R7 read data (stop)",
                b, model[p]);
            p = nxt(p, inc);
        end
        wq();
        chk(sda_oe == 0, "R6 released after host nack", sda_oe, 0);
        bus_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R8 watchdog actual=timeout expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit a;
        int bad;
        int seed;
        logic [7:0] b;
        seed = int'($urandom(32'd2024));
        for (int i = 0; i < NREG; i++) begin
            rf[i]    = 8'(i * 37 + 5);
            model[i] = 8'(i * 37 + 5);
        end
        rst_n = 0; scl_drv = 1; host_low = 0; strap = 0;
        repeat (5) @(posedge clk);
        #1;
        chk(sda_oe == 0 && reg_wr_en == 0, "R9 reset outputs quiet", {sda_oe, reg_wr_en}, 0);
        rst_n = 1;
        wq(2);
        chk(sda_oe == 0, "R9 idle after reset", sda_oe, 0);

        // Directed: incrementing write/read with each strap level
        strap = 0;
        wbuf[0] = 8'hA5; wbuf[1] = 8'h3C; wbuf[2] = 8'hF0;
        do_write(5, 1, 3);
        do_read(5, 1, 3, 1);
        strap = 1;
        wbuf[0] = 8'h11; wbuf[1] = 8'h22;
        do_write(40, 1, 2);
        do_read(40, 1, 2, 0);

        // R2: address with the wrong strap bit is ignored
        bus_start();
        send_byte(addr_byte(1'b0, 1'b0), a);
        chk(!a, "R2 mismatched address not acked", a, 0);
        send_byte(8'h85, a);
        chk(!a, "R2 following byte not acked", a, 0);
        send_byte(8'hEE, a);
        chk(!a, "R2 data byte not acked", a, 0);
        bus_stop();
        chk(rf[5] == model[5], "R2 register untouched", rf[5], model[5]);

        // R4: fixed pointer write, all bytes go to one register
        wbuf[0] = 8'h01; wbuf[1] = 8'h02; wbuf[2] = 8'h7E;
        do_write(9, 0, 3);
        chk(rf[9] == 8'h7E, "R4 fixed pointer final value", rf[9], 8'h7E);
        chk(rf[10] == model[10], "R4 neighbour untouched", rf[10], model[10]);
        do_read(9, 0, 2, 1);

        // R4: wrap from the last register to 0
        wbuf[0] = 8'hC3; wbuf[1] = 8'h5A;
        do_write(NREG - 1, 1, 2);
        chk(rf[0] == 8'h5A, "R4 wrap to register 0", rf[0], 8'h5A);
        do_read(NREG - 1, 1, 2, 1);

        // R7: pointer retained over a stop with a pointer-only write
        bus_start();
        send_byte(addr_byte(strap, 1'b0), a);
        send_byte(8'h05, a);
        bus_stop();
        bus_start();
        send_byte(addr_byte(strap, 1'b1), a);
        recv_byte(b, 1);
        chk(b == model[5], "R7 pointer kept over stop", b, model[5]);
        bus_stop();

        // R8: stop in the middle of a pointer byte
        bus_start();
        send_byte(addr_byte(strap, 1'b0), a);
        send_bits(8'h10, 3);
        bus_stop();
        wq();
        chk(sda_oe == 0, "R8 idle after mid-byte stop", sda_oe, 0);
        wbuf[0] = 8'h99;
        do_write(20, 1, 1);
        do_read(20, 1, 1, 1);

        // Constrained random transfers
        for (int it = 0; it < 12; it++) begin
            int idx;
            int n;
            bit inc;
            strap = 1'($urandom);
            idx = int'($urandom % NREG);
            inc = 1'($urandom);
            n = 1 + int'($urandom % 4);
            for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
            do_write(idx, inc, n);
            do_read(idx, inc, inc ? n : 2, 1'($urandom));
        end

        // R3: whole register file matches the model
        bad = 0;
        for (int i = 0; i < NREG; i++) if (rf[i] !== model[i]) bad++;
        chk(bad == 0, "R3 register file contents", bad, 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule